// File: doc/BRIEF.md
# Secure Gateway Entry Checker

This block watches every instruction fetch and data access a core issues and decides, from the current security state, the access kind and the security attribute of the target, whether the access may proceed and which security state the core occupies afterwards. A legal way into the secure state exists only through a fetch of the gateway opcode from a non-secure-callable (NSC) region. Every other path raises a secure fault, and the core handles that fault in the secure state.

The core presents one request per cycle with `req_valid`, the access kind, its present state, the attribute returned by the attribution logic, a one-bit flag from the decoder that says whether the fetched word is the gateway opcode, and, for a secure-to-non-secure branch, the least significant bit of the branch target. One cycle later the checker returns allow or deny, the next state and a one-cycle fault pulse. The first fault cause since the last software clear stays readable on `fault_cause`.

Top module: `sgc_entry_checker`

## Requirements
- R1: After reset `res_valid`, `res_allow` and `fault_pulse` are 0, `res_next_secure` is 1 and `fault_cause` is 0.
- R2: Data accesses (`req_kind` 0, and reserved kind 3 handled the same way) are allowed in the secure state for any attribute. In the non-secure state they are allowed for attribute 0 (non-secure) and denied with cause 2 for attribute 1 (secure), 2 (NSC) or 3 (reserved, treated as secure).
- R3: A fetch (`req_kind` 1) from the non-secure state is allowed with next state non-secure for attribute 0, and denied with cause 4 for attributes 1 or 3.
- R4: A fetch from the non-secure state of attribute 2 with `gw_match`=1 is allowed, and `res_next_secure` becomes 1.
- R5: A fetch of attribute 2 with `gw_match`=0 is denied with cause 1 (invalid entry point), from the non-secure state and, with the default strict option, from the secure state. A secure fetch of attribute 1 or 3, or of attribute 2 with `gw_match`=1, is allowed and stays secure.
- R6: A fetch from the secure state of attribute 0 is denied with cause 5.
- R7: A branch to the non-secure state (`req_kind` 2) issued in the secure state is allowed with next state 0 when `target_lsb`=0. It is denied with cause 3 when `target_lsb`=1. In the non-secure state the branch is allowed and stays non-secure, whatever the attribute.
- R8: Every denial has `res_allow`=0, `res_next_secure`=1, and exactly one `fault_pulse` cycle for each denied request.
- R9: With the default keep-first option, `fault_cause` loads a new cause only when it is 0 or `cause_clr` is 1 in the same cycle. Otherwise it holds. `cause_clr` with no fault sets it to 0 on the next cycle.
- R10: A result (`res_valid`=1) appears exactly one cycle after each request, and never in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 0 data, 1 fetch, 2 branch to non-secure, 3 reserved (as data) |
| cur_secure | input | 1 | Core is in the secure state |
| attr | input | 2 | Target attribute: 0 non-secure, 1 secure, 2 NSC, 3 reserved |
| gw_match | input | 1 | Fetched word is the gateway opcode |
| target_lsb | input | 1 | Bit 0 of the branch target |
| cause_clr | input | 1 | Software clear of the held fault cause |
| res_valid | output | 1 | Result for the previous cycle's request |
| res_allow | output | 1 | Access permitted |
| res_next_secure | output | 1 | Security state after the request |
| fault_pulse | output | 1 | One-cycle secure-fault indication |
| fault_cause | output | 3 | Held cause: 0 none, 1 entry, 2 data, 3 transition, 4 secure fetch, 5 non-secure fetch |

## Verification
The assertions take for granted that `cur_secure` reflects the state the core actually holds, and that `gw_match` and `target_lsb` are meaningful only for fetches and branches respectively. The checks on the one-cycle response rely on the default registered output. The stimulus keeps within these limits by driving every input only at the falling edge, by holding each request for a single cycle, and by using only the encodings listed in the requirements. It covers each kind, state and attribute combination, back-to-back faults, and clears issued both alone and together with a fault.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   localparam int CAUSE_W = 3;
   localparam int ATTR_W  = 2;
   localparam int KIND_W  = 2;

   typedef enum logic [KIND_W-1:0] {
      K_DATA  = 2'd0,
      K_FETCH = 2'd1,
      K_BRNS  = 2'd2,
      K_RSVD  = 2'd3
   } kind_e;

   localparam logic [ATTR_W-1:0] A_NS  = 2'd0;
   localparam logic [ATTR_W-1:0] A_S   = 2'd1;
   localparam logic [ATTR_W-1:0] A_NSC = 2'd2;

   localparam logic [CAUSE_W-1:0] C_NONE    = 3'd0;
   localparam logic [CAUSE_W-1:0] C_ENTRY   = 3'd1;
   localparam logic [CAUSE_W-1:0] C_SDATA   = 3'd2;
   localparam logic [CAUSE_W-1:0] C_XFER    = 3'd3;
   localparam logic [CAUSE_W-1:0] C_SFETCH  = 3'd4;
   localparam logic [CAUSE_W-1:0] C_NSFETCH = 3'd5;

   typedef struct packed {
      logic               allow;
      logic               nsec;
      logic               fault;
      logic [CAUSE_W-1:0] cause;
   } verdict_t;

   localparam verdict_t VERDICT_RST = '{allow: 1'b0, nsec: 1'b1, fault: 1'b0, cause: C_NONE};

endpackage

// File: rtl/sgc_rule_eval.sv
module sgc_rule_eval
   import sgc_pkg::*;
#(
   parameter bit NSC_STRICT = 1'b1
) (
   input  logic [KIND_W-1:0] kind,
   input  logic              cur_secure,
   input  logic [ATTR_W-1:0] attr,
   input  logic              gw_match,
   input  logic              target_lsb,
   output verdict_t          verdict
);

   logic at_ns, at_nsc, at_sec;

   assign at_ns  = (attr == A_NS);
   assign at_nsc = (attr == A_NSC);
   assign at_sec = !at_ns && !at_nsc;

   function automatic verdict_t deny(input logic [CAUSE_W-1:0] c);
      verdict_t d;
      d.allow = 1'b0;
      d.nsec  = 1'b1;
      d.fault = 1'b1;
      d.cause = c;
      return d;
   endfunction

   always_comb begin
      verdict = '{allow: 1'b1, nsec: cur_secure, fault: 1'b0, cause: C_NONE};
      unique case (kind_e'(kind))
         K_FETCH: begin
            if (cur_secure) begin
               if (at_ns)
                  verdict = deny(C_NSFETCH);
               else if (at_nsc && !gw_match && NSC_STRICT)
                  verdict = deny(C_ENTRY);
            end else begin
               if (at_nsc) begin
                  if (gw_match) verdict.nsec = 1'b1;
                  else          verdict = deny(C_ENTRY);
               end else if (at_sec) begin
                  verdict = deny(C_SFETCH);
               end
            end
         end
         K_BRNS: begin
            if (cur_secure) begin
               if (target_lsb) verdict = deny(C_XFER);
               else            verdict.nsec = 1'b0;
            end
         end
         default: begin
            if (!cur_secure && !at_ns)
               verdict = deny(C_SDATA);
         end
      endcase
   end

endmodule

// File: rtl/sgc_out_stage.sv
module sgc_out_stage
   import sgc_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     in_valid,
   input  verdict_t in_verdict,
   output logic     out_valid,
   output logic     out_allow,
   output logic     out_nsec,
   output logic     out_fault
);

   logic     vld_q;
   verdict_t ver_q;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               ver_q <= VERDICT_RST;
            end else begin
               vld_q <= in_valid;
               if (in_valid) ver_q <= in_verdict;
            end
         end
      end else begin : g_comb
         assign vld_q = in_valid;
         assign ver_q = in_valid ? in_verdict : VERDICT_RST;
      end
   endgenerate

   assign out_valid = vld_q;
   assign out_allow = vld_q && ver_q.allow;
   assign out_nsec  = ver_q.nsec;
   assign out_fault = vld_q && ver_q.fault;

   // R8: a fault always comes with a denial and a secure landing state
   a_r8_fault_denies: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_valid && !out_allow && out_nsec));

endmodule

// File: rtl/sgc_cause_log.sv
module sgc_cause_log
   import sgc_pkg::*;
#(
   parameter bit KEEP_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fault,
   input  logic [CAUSE_W-1:0] cause_in,
   input  logic               clr,
   output logic [CAUSE_W-1:0] cause_q
);

   logic load;

   generate
      if (KEEP_FIRST) begin : g_first
         assign load = fault && (clr || (cause_q == C_NONE));

         // R9: a held cause survives later faults until cleared
         a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q != C_NONE && !clr) |=> (cause_q == $past(cause_q)));
      end else begin : g_last
         assign load = fault;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cause_q <= C_NONE;
      else if (load)  cause_q <= cause_in;
      else if (clr)   cause_q <= C_NONE;
   end

   // R9: a clear without a new fault empties the register
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fault) |=> (cause_q == C_NONE));

endmodule

// File: rtl/sgc_entry_checker.sv
module sgc_entry_checker
   import sgc_pkg::*;
#(
   parameter bit REG_OUT    = 1'b1,
   parameter bit KEEP_FIRST = 1'b1,
   parameter bit NSC_STRICT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [KIND_W-1:0]  req_kind,
   input  logic               cur_secure,
   input  logic [ATTR_W-1:0]  attr,
   input  logic               gw_match,
   input  logic               target_lsb,
   input  logic               cause_clr,
   output logic               res_valid,
   output logic               res_allow,
   output logic               res_next_secure,
   output logic               fault_pulse,
   output logic [CAUSE_W-1:0] fault_cause
);

   generate
      if (CAUSE_W < 3) begin : g_bad_cause
         $error("sgc_entry_checker: cause width too small for six codes");
      end
      if (ATTR_W != 2 || KIND_W != 2) begin : g_bad_enc
         $error("sgc_entry_checker: attribute and kind encodings are two bits");
      end
   endgenerate

   verdict_t ver;

   sgc_rule_eval #(.NSC_STRICT(NSC_STRICT)) u_eval (
      .kind       (req_kind),
      .cur_secure (cur_secure),
      .attr       (attr),
      .gw_match   (gw_match),
      .target_lsb (target_lsb),
      .verdict    (ver)
   );

   sgc_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (req_valid),
      .in_verdict (ver),
      .out_valid  (res_valid),
      .out_allow  (res_allow),
      .out_nsec   (res_next_secure),
      .out_fault  (fault_pulse)
   );

   sgc_cause_log #(.KEEP_FIRST(KEEP_FIRST)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault    (req_valid && ver.fault),
      .cause_in (ver.cause),
      .clr      (cause_clr),
      .cause_q  (fault_cause)
   );

   generate
      if (REG_OUT) begin : g_timing_props
         // R10: results only follow requests
         a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !res_valid);
         // R2: non-secure data reaching secure memory is refused
         a_r2_ns_data_denied: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_kind == K_DATA && !cur_secure && attr == A_S)
            |=> (fault_pulse && !res_allow));
         // R4: gateway fetch from NSC enters the secure state
         a_r4_gateway_entry: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_kind == K_FETCH && !cur_secure && attr == A_NSC && gw_match)
            |=> (res_allow && res_next_secure && !fault_pulse));
         // R7: an odd branch target faults and stays secure
         a_r7_odd_target: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_kind == K_BRNS && cur_secure && target_lsb)
            |=> (fault_pulse && res_next_secure));
      end
   endgenerate

endmodule

// File: tb/sgc_entry_checker_bench.sv
module sgc_entry_checker_bench;

   typedef struct {
      logic       allow;
      logic       nsec;
      logic       fault;
      logic [2:0] cause;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic       cur_secure = 1'b0;
   logic [1:0] attr = 2'd0;
   logic       gw_match = 1'b0;
   logic       target_lsb = 1'b0;
   logic       cause_clr = 1'b0;
   logic       res_valid, res_allow, res_next_secure, fault_pulse;
   logic [2:0] fault_cause;

   int checks = 0;
   int fails  = 0;
   item_t exp_q[$];
   logic [2:0] model_cause = 3'd0;

   always #2 clk = ~clk;

   sgc_entry_checker u_sgc_entry_checker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .cur_secure(cur_secure), .attr(attr), .gw_match(gw_match),
      .target_lsb(target_lsb), .cause_clr(cause_clr), .res_valid(res_valid),
      .res_allow(res_allow), .res_next_secure(res_next_secure),
      .fault_pulse(fault_pulse), .fault_cause(fault_cause)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // expected verdict taken from the requirement text
   function automatic item_t predict(input logic [1:0] k, input logic s,
                                     input logic [1:0] a, input logic g, input logic l);
      item_t it;
      logic [2:0] c = 3'd0;
      it.nsec = s;
      if (k == 2'd1) begin
         if (s) begin
            if (a == 2'd0) c = 3'd5;
            else if (a == 2'd2 && !g) c = 3'd1;
         end else begin
            if (a == 2'd2) begin
               if (g) it.nsec = 1'b1; else c = 3'd1;
            end else if (a != 2'd0) c = 3'd4;
         end
      end else if (k == 2'd2) begin
         if (s) begin
            if (l) c = 3'd3; else it.nsec = 1'b0;
         end
      end else begin
         if (!s && a != 2'd0) c = 3'd2;
      end
      it.fault = (c != 3'd0);
      it.allow = !it.fault;
      if (it.fault) it.nsec = 1'b1;
      it.cause = c;
      return it;
   endfunction

   task automatic send(input string tag, input logic [1:0] k, input logic s,
                       input logic [1:0] a, input logic g, input logic l,
                       input logic clr = 1'b0);
      item_t it;
      it = predict(k, s, a, g, l);
      if (it.fault && (clr || model_cause == 3'd0)) model_cause = it.cause;
      else if (clr) model_cause = 3'd0;
      it.cause = model_cause;
      it.tag = tag;
      exp_q.push_back(it);
      req_valid = 1'b1; req_kind = k; cur_secure = s; attr = a;
      gw_match = g; target_lsb = l; cause_clr = clr;
      @(negedge clk);
      req_valid = 1'b0; cause_clr = 1'b0;
   endtask

   task automatic clear_only();
      cause_clr = 1'b1;
      model_cause = 3'd0;
      @(negedge clk);
      cause_clr = 1'b0;
      @(negedge clk);
      check(fault_cause == model_cause, "R9", "cause after clear", fault_cause, model_cause);
   endtask

   // monitor: pop one expected item per result
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10", "result with no request", 1, 0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            check(res_allow == e.allow, e.tag, "allow", res_allow, e.allow);
            check(res_next_secure == e.nsec, e.tag, "next_secure", res_next_secure, e.nsec);
            check(fault_pulse == e.fault, e.tag, "fault_pulse", fault_pulse, e.fault);
            check(fault_cause == e.cause, e.tag, "fault_cause", fault_cause, e.cause);
         end
      end else if (rst_n) begin
         if (fault_pulse) check(1'b0, "R8", "fault without result", 1, 0);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check(res_valid == 0 && res_allow == 0 && fault_pulse == 0, "R1", "flags",
            {res_valid, res_allow, fault_pulse}, 0);
      check(res_next_secure == 1, "R1", "next_secure", res_next_secure, 1);
      check(fault_cause == 0, "R1", "cause", fault_cause, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 0, "R10", "idle after reset", res_valid, 0);

      // R2 data
      send("R2", 2'd0, 1, 2'd1, 0, 0);
      send("R2", 2'd0, 1, 2'd0, 0, 0);
      send("R2", 2'd0, 0, 2'd0, 0, 0);
      send("R2", 2'd3, 0, 2'd0, 0, 0);
      send("R2", 2'd0, 0, 2'd1, 0, 0);
      clear_only();
      send("R2", 2'd0, 0, 2'd2, 0, 0);
      clear_only();
      send("R2", 2'd3, 0, 2'd3, 0, 0);
      clear_only();
      // R3 fetch from non-secure
      send("R3", 2'd1, 0, 2'd0, 0, 0);
      send("R3", 2'd1, 0, 2'd1, 0, 0);
      clear_only();
      send("R3", 2'd1, 0, 2'd3, 1, 0);
      clear_only();
      // R4 gateway
      send("R4", 2'd1, 0, 2'd2, 1, 0);
      // R5 invalid entry and secure fetches
      send("R5", 2'd1, 0, 2'd2, 0, 0);
      clear_only();
      send("R5", 2'd1, 1, 2'd2, 0, 0);
      clear_only();
      send("R5", 2'd1, 1, 2'd2, 1, 0);
      send("R5", 2'd1, 1, 2'd1, 0, 0);
      send("R5", 2'd1, 1, 2'd3, 0, 0);
      // R6 non-secure code from secure
      send("R6", 2'd1, 1, 2'd0, 0, 0);
      clear_only();
      // R7 branches
      send("R7", 2'd2, 1, 2'd0, 0, 0);
      send("R7", 2'd2, 1, 2'd0, 0, 1);
      clear_only();
      send("R7", 2'd2, 0, 2'd1, 0, 0);
      send("R7", 2'd2, 0, 2'd0, 0, 1);
      // R8 back-to-back faults each pulse; R9 first cause kept
      send("R8", 2'd0, 0, 2'd1, 0, 0);
      send("R8", 2'd1, 1, 2'd0, 0, 0);
      send("R9", 2'd2, 1, 2'd0, 0, 1);
      send("R8", 2'd0, 0, 2'd0, 0, 0);
      // R9 clear together with a fault loads the new cause
      send("R9", 2'd1, 0, 2'd1, 0, 0, 1'b1);
      // R9 clear together with an allowed request empties
      send("R9", 2'd0, 1, 2'd0, 0, 0, 1'b1);
      // R10 idle gap then a single request
      repeat (3) @(negedge clk);
      send("R10", 2'd1, 0, 2'd0, 0, 0);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule